// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block stands between the external control pins of a processor core and the core's interrupt and run-control logic. The pins are presented one update at a time: an update carries a pin index and the pin's new level. The block holds a registered copy of the last level seen on every pin. It reacts only when an update carries a level that differs from the stored copy, and it then stores the new level.

Pin changes are turned into three kinds of result. The first is a pending-interrupt vector, together with a summary hard-interrupt request. The second is the run-control outputs: halt, a core-reset pulse and time-base run. The third is sticky state that only the core can clear. The core clears pending bits through a per-bit acknowledge input. Each pin has its own behaviour: some are level sensitive and active high, some are active low, and the machine-check pin records a falling edge.

Top module: `pin_cond`

## Requirements
- R1: An update whose level equals the stored level of that pin has no effect on any output. An update with a different level performs the pin's action, and the stored level then becomes the new level.
- R2: Pin index 0 (external interrupt) and pin index 1 (management interrupt) are active high. A change to 1 sets pending bit 0 or bit 1 respectively, and a change to 0 clears that bit.
- R3: On pin index 2 (machine check), a 1-to-0 change sets pending bit 2. A 0-to-1 change leaves pending bit 2 unchanged.
- R4: Pending bit 2 stays set until ack[2] is asserted. If ack[2] arrives in the same cycle as a new falling edge on pin 2, the bit stays set.
- R5: Pin index 3 (checkstop) is active low. A change to 0 sets `halt`. `halt` then stays 1, whatever the pin does, until the block is reset.
- R6: Pin index 4 (hard reset) is active low. A change to 0 produces a `core_rst` pulse exactly one cycle long. A change to 1 produces no pulse.
- R7: Pin index 5 (soft reset) drives pending bit 3: a change to 1 sets it and a change to 0 clears it.
- R8: Pin index 6 (time-base enable) is active high. `tb_run` takes the new level of each change on that pin.
- R9: `irq_req` is 1 in every cycle where the pending vector is nonzero, and 0 only when the whole vector is zero.
- R10: An update with pin index 7, which is outside the defined set, changes no output and no stored level.
- R11: `ack[i]` clears pending bit i. A pin change that writes bit i in the same cycle takes priority over the acknowledge.
- R12: All outputs are registered. An update or acknowledge becomes visible after the next clock edge. While reset is active, every output and every stored pin level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_vld | input | 1 | A pin update is present this cycle |
| upd_idx | input | 3 | Index of the pin being updated |
| upd_lvl | input | 1 | New level of that pin |
| ack | input | 4 | Per-bit clear of the pending vector from the core |
| pend | output | 4 | Pending vector: bit0 external, bit1 management, bit2 machine check, bit3 soft reset |
| irq_req | output | 1 | Summary hard-interrupt request |
| halt | output | 1 | Core stopped by checkstop, cleared only by reset |
| core_rst | output | 1 | One-cycle core reset pulse |
| tb_run | output | 1 | Time base runs while 1 |

## Verification
Repeated updates at the same level are interleaved with real changes. This separates change-only behaviour from plain level following, and the acknowledge shows it clearly: a level bit cleared by an acknowledge while its pin is still high stays clear. The machine-check pin is driven with rising and falling edges, with and without a same-cycle acknowledge, to tell edge capture apart from level capture and to confirm that the edge wins over the acknowledge. The active-low pins are toggled in both directions, which shows that only the falling change acts and that halt survives a later rise. An update with an out-of-range index is issued after a known state has been set up, so that any stray write would show up on the outputs.

// File: rtl/pin_cond_pkg.sv
package pin_cond_pkg;
  localparam int PIN_CNT    = 7;
  localparam int PIN_EXT    = 0;
  localparam int PIN_MGMT   = 1;
  localparam int PIN_MCHK   = 2;
  localparam int PIN_STOP_N = 3;
  localparam int PIN_HRST_N = 4;
  localparam int PIN_SRST   = 5;
  localparam int PIN_TBEN   = 6;

  localparam int PND_W    = 4;
  localparam int PND_EXT  = 0;
  localparam int PND_MGMT = 1;
  localparam int PND_MCHK = 2;
  localparam int PND_SRST = 3;

  typedef struct packed {
    logic [PIN_CNT-1:0] chg;  // pin changed this cycle
    logic [PIN_CNT-1:0] lvl;  // level carried by the update
  } pin_evt_t;
endpackage

// File: rtl/pin_track.sv
module pin_track
  import pin_cond_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_vld,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_lvl,
  output pin_evt_t         evt
);
  logic [PIN_CNT-1:0] lvl_q;
  logic [PIN_CNT-1:0] lvl_d;

  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    logic hit;
    always_comb begin
      hit          = upd_vld && (upd_idx == IDX_W'(i));
      evt.chg[i]   = hit && (upd_lvl != lvl_q[i]);
      evt.lvl[i]   = upd_lvl;
      lvl_d[i]     = evt.chg[i] ? upd_lvl : lvl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/pend_ctl.sv
module pend_ctl
  import pin_cond_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PND_W-1:0] ev_wr,
  input  logic [PND_W-1:0] ev_val,
  input  logic [PND_W-1:0] ack,
  output logic [PND_W-1:0] pend,
  output logic             irq_req
);
  logic [PND_W-1:0] pend_d;
  logic             irq_d;

  for (genvar i = 0; i < PND_W; i++) begin : g_bit
    always_comb begin
      if (ev_wr[i])    pend_d[i] = ev_val[i];
      else if (ack[i]) pend_d[i] = 1'b0;
      else             pend_d[i] = pend[i];
    end
  end

  always_comb irq_d = |pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      irq_req <= 1'b0;
    end else begin
      pend    <= pend_d;
      irq_req <= irq_d;
    end
  end
endmodule

// File: rtl/run_ctl.sv
module run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_chg,
  input  logic stop_lvl,
  input  logic hrst_chg,
  input  logic hrst_lvl,
  input  logic tben_chg,
  input  logic tben_lvl,
  output logic halt,
  output logic core_rst,
  output logic tb_run
);
  logic halt_d;
  logic rst_d;
  logic tb_d;
  logic tb_en;

  always_comb begin
    halt_d = halt | (stop_chg & ~stop_lvl);
    rst_d  = hrst_chg & ~hrst_lvl;
    tb_en  = tben_chg;
    tb_d   = tben_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt     <= 1'b0;
      core_rst <= 1'b0;
    end else begin
      halt     <= halt_d;
      core_rst <= rst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tb_run <= 1'b0;
    else if (tb_en) tb_run <= tb_d;
  end
endmodule

// File: rtl/pin_cond.sv
module pin_cond
  import pin_cond_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             upd_vld,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_lvl,
  input  logic [PND_W-1:0] ack,
  output logic [PND_W-1:0] pend,
  output logic             irq_req,
  output logic             halt,
  output logic             core_rst,
  output logic             tb_run
);
  logic [1:0]       rst_sync;
  logic             rst_n;
  pin_evt_t         evt;
  logic [PND_W-1:0] ev_wr;
  logic [PND_W-1:0] ev_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= '0;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  pin_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .upd_idx(upd_idx),
    .upd_lvl(upd_lvl), .evt(evt)
  );

  // route pin events onto pending-bit writes
  always_comb begin
    ev_wr            = '0;
    ev_val           = '0;
    ev_wr[PND_EXT]   = evt.chg[PIN_EXT];
    ev_val[PND_EXT]  = evt.lvl[PIN_EXT];
    ev_wr[PND_MGMT]  = evt.chg[PIN_MGMT];
    ev_val[PND_MGMT] = evt.lvl[PIN_MGMT];
    ev_wr[PND_MCHK]  = evt.chg[PIN_MCHK] & ~evt.lvl[PIN_MCHK];
    ev_val[PND_MCHK] = 1'b1;
    ev_wr[PND_SRST]  = evt.chg[PIN_SRST];
    ev_val[PND_SRST] = evt.lvl[PIN_SRST];
  end

  pend_ctl u_pend (
    .clk(clk), .rst_n(rst_n), .ev_wr(ev_wr), .ev_val(ev_val), .ack(ack),
    .pend(pend), .irq_req(irq_req)
  );

  run_ctl u_run (
    .clk(clk), .rst_n(rst_n),
    .stop_chg(evt.chg[PIN_STOP_N]), .stop_lvl(evt.lvl[PIN_STOP_N]),
    .hrst_chg(evt.chg[PIN_HRST_N]), .hrst_lvl(evt.lvl[PIN_HRST_N]),
    .tben_chg(evt.chg[PIN_TBEN]),   .tben_lvl(evt.lvl[PIN_TBEN]),
    .halt(halt), .core_rst(core_rst), .tb_run(tb_run)
  );
endmodule

// File: rtl/pin_cond_chk.sv
module pin_cond_chk
  import pin_cond_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             arst_n,
  input logic             upd_vld,
  input logic [IDX_W-1:0] upd_idx,
  input logic [PND_W-1:0] ack,
  input logic [PND_W-1:0] pend,
  input logic             irq_req,
  input logic             halt,
  input logic             core_rst,
  input logic             tb_run
);
  a_r4_mchk_sticky: assert property (@(posedge clk) disable iff (!arst_n)
    (pend[PND_MCHK] && !ack[PND_MCHK]) |=> pend[PND_MCHK]);

  a_r9_irq_covers: assert property (@(posedge clk) disable iff (!arst_n)
    (pend != '0) |-> irq_req);

  a_r9_irq_falls_clean: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(irq_req) |-> (pend == '0));

  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!arst_n)
    halt |=> halt);

  a_r6_rst_single: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst |=> !core_rst);

  a_r10_oob_quiet: assert property (@(posedge clk) disable iff (!arst_n)
    (upd_vld && upd_idx >= IDX_W'(PIN_CNT) && ack == '0)
      |=> ($stable(pend) && $stable(tb_run) && !core_rst));
endmodule

bind pin_cond pin_cond_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .upd_vld(upd_vld), .upd_idx(upd_idx),
  .ack(ack), .pend(pend), .irq_req(irq_req), .halt(halt),
  .core_rst(core_rst), .tb_run(tb_run)
);

// File: tb/pin_cond_bench.sv
module pin_cond_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       upd_vld = 1'b0;
  logic [2:0] upd_idx = '0;
  logic       upd_lvl = 1'b0;
  logic [3:0] ack = '0;
  logic [3:0] pend;
  logic       irq_req, halt, core_rst, tb_run;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state built from the requirements
  logic [6:0] m_lvl = '0;
  logic [3:0] m_pend = '0;
  logic       m_halt = 0;
  logic       m_tb = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_cond u_pin_cond (
    .clk(clk), .arst_n(arst_n), .upd_vld(upd_vld), .upd_idx(upd_idx),
    .upd_lvl(upd_lvl), .ack(ack), .pend(pend), .irq_req(irq_req),
    .halt(halt), .core_rst(core_rst), .tb_run(tb_run)
  );

  function automatic logic [7:0] pack_exp(input logic rst);
    return {m_tb, rst, m_halt, |m_pend, m_pend};
  endfunction

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      logic [7:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {tb_run, core_rst, halt, irq_req, pend};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: act tb/rst/halt/irq/pend=%b exp=%b", t, a, e);
      end
    end
  end

  task automatic step(input logic v, input logic [2:0] idx, input logic l,
                      input logic [3:0] a, input string tag);
    logic rst_e;
    @(negedge clk);
    upd_vld = v; upd_idx = idx; upd_lvl = l; ack = a;
    rst_e = 1'b0;
    m_pend = m_pend & ~a;
    if (v && idx < 3'd7 && l != m_lvl[idx]) begin
      case (idx)
        3'd0: m_pend[0] = l;
        3'd1: m_pend[1] = l;
        3'd2: if (!l) m_pend[2] = 1'b1;
        3'd3: if (!l) m_halt = 1'b1;
        3'd4: if (!l) rst_e = 1'b1;
        3'd5: m_pend[3] = l;
        default: m_tb = l;
      endcase
      m_lvl[idx] = l;
    end
    @(posedge clk);
    #1;
    upd_vld = 1'b0; ack = '0;
    exp_q.push_back(pack_exp(rst_e));
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    arst_n = 1'b0;
    m_lvl = '0; m_pend = '0; m_halt = 0; m_tb = 0;
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    exp_q.push_back(pack_exp(1'b0));
    tag_q.push_back(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finish_run();
  end

  initial begin
    // R12 reset state, sampled while reset is still held
    #(CLK_PERIOD + 2);
    total++;
    if ({tb_run, core_rst, halt, irq_req, pend} !== 8'h00) begin
      bad++;
      $display("FAIL R12 in reset: act=%b exp=00000000",
               {tb_run, core_rst, halt, irq_req, pend});
    end
    do_reset("R12 after reset release");

    step(1, 3'd0, 1, 4'h0, "R2 ext high sets bit0");
    step(1, 3'd0, 1, 4'h1, "R1 R11 repeat level with ack clears and no re-set");
    step(1, 3'd0, 0, 4'h0, "R2 ext low change");
    step(1, 3'd1, 1, 4'h0, "R2 mgmt high sets bit1");
    step(1, 3'd1, 1, 4'h0, "R1 repeated mgmt level no effect");
    step(1, 3'd1, 0, 4'h0, "R9 mgmt low clears, irq falls");
    step(1, 3'd2, 1, 4'h0, "R3 mchk rise no effect");
    step(1, 3'd2, 0, 4'h0, "R3 mchk fall sets bit2");
    step(0, 3'd0, 0, 4'h0, "R4 mchk holds without ack");
    step(1, 3'd2, 0, 4'h0, "R1 repeated low on mchk no effect");
    step(0, 3'd0, 0, 4'h4, "R4 ack clears bit2");
    step(1, 3'd2, 1, 4'h0, "R3 mchk rise again");
    step(1, 3'd2, 0, 4'h4, "R4 R11 fall with ack keeps bit2");
    step(1, 3'd0, 1, 4'h0, "R9 ext plus mchk");
    step(0, 3'd0, 0, 4'h4, "R9 irq stays while ext pending");
    step(1, 3'd0, 1, 4'h1, "R11 ack bit0 pin unchanged");
    step(1, 3'd5, 1, 4'h0, "R7 soft reset sets bit3");
    step(1, 3'd5, 0, 4'h0, "R7 soft reset clears bit3");
    step(1, 3'd6, 1, 4'h0, "R8 tb enable high");
    step(1, 3'd7, 0, 4'h0, "R10 out of range index low");
    step(1, 3'd7, 1, 4'h0, "R10 out of range index high");
    step(1, 3'd6, 0, 4'h0, "R8 tb enable low freezes");
    step(1, 3'd4, 1, 4'h0, "R6 hreset rise no pulse");
    step(1, 3'd4, 0, 4'h0, "R6 hreset fall pulse");
    step(0, 3'd0, 0, 4'h0, "R6 pulse is one cycle");
    step(1, 3'd4, 0, 4'h0, "R1 R6 repeated low no pulse");
    step(1, 3'd3, 1, 4'h0, "R5 checkstop rise no halt");
    step(1, 3'd3, 0, 4'h0, "R5 checkstop fall halts");
    step(1, 3'd3, 1, 4'h0, "R5 halt stays after rise");
    step(1, 3'd5, 1, 4'h0, "R7 bit3 set before reset");
    do_reset("R12 R5 reset clears halt and pending");
    step(1, 3'd5, 0, 4'h0, "R12 stored level cleared so low is no change");

    wait (exp_q.size() == 0);
    @(posedge clk);
    finish_run();
  end
endmodule